// File: doc/BRIEF.md
# Multi-Digit Zero-Suppressing Seven-Segment Front End

This block takes a packed binary-coded-decimal number of `NDIG` digits (eight by default), a decimal-point position and a suppression switch. It produces one seven-segment pattern and one decimal-point bit per digit. Each digit has its own segment decoder. Two blanking chains run across the decoders. The integer-side chain starts at the most significant digit and runs down toward the point. The fractional-side chain starts at the least significant digit and runs up toward the point. With these chains a number such as 00000077 shows as "77" and 7.7000000 shows as "7.7".

Digit 0 is the least significant digit. The decimal-point index names the units digit, which is the digit just left of the point and carries the lit point. Digits above the index are integer digits. Digits below it are fractional digits. The units digit never blanks, so a value of zero still shows a single "0." on the display. Scanning the digits onto a shared display and any timing of that scan belong to the logic outside this block.

All outputs are registered, so a result appears one clock after its inputs are sampled. The reset is asynchronous and active low. Its release is synchronised inside the block.

Top module: `zs_display_top`

## Requirements
- R1: While reset is held, and until the first clock edge after its synchronised release, every segment output and every decimal-point output is 0.
- R2: Outputs change only at a rising clock edge. The value captured at edge k is shown from edge k until edge k+1.
- R3: Segments are active high. Digit i uses `seg_o[7*i +: 7]`, with bit 0 = a, bit 1 = b, and so on up to bit 6 = g. The codes for 0 to 9, written as hex of g..a, are 3F, 06, 5B, 4F, 66, 6D, 7D, 7F for 8, 07 for 7 and 6F for 9. The 6 and the 9 both have their tail. Digit i reads `bcd_in[4*i +: 4]`.
- R4: `dp_o[i]` is 1 exactly for i equal to `dp_idx`. All other decimal-point bits are 0.
- R5: With suppression on, an integer digit i > `dp_idx` is blank when it and every more significant digit are 0.
- R6: With suppression on, a fractional digit i < `dp_idx` is blank when it and every less significant digit are 0.
- R7: The units digit at `dp_idx` is never blanked by suppression. A zero there shows as "0".
- R8: With `sup_en` low, no digit is blanked by the zero chains. Every digit holding 0 to 9 shows its code.
- R9: A digit holding 10 to 15 is blank. It also ends the zero chain at that digit, so zeros beyond it on the same side are shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_in | input | 4*NDIG | Packed digits, digit 0 in the low nibble |
| dp_idx | input | IW | Index of the units digit that carries the point |
| sup_en | input | 1 | Zero suppression enable |
| seg_o | output | 7*NDIG | Registered segment patterns, 7 bits per digit |
| dp_o | output | NDIG | Registered decimal-point bits |

## Verification
Both blanking chains, and the invalid-digit blank, can act in the same cycle on different digits. A single digit can also meet the end of one chain and an invalid code at once. Directed vectors provoke these overlaps: all-zero words with the point in the middle, an invalid code sitting above zeros, and point positions at both ends. Random words biased heavily toward zero digits, mixed with occasional invalid codes, hit overlaps that were not planned. Each output word is judged against a bench model. That model defines blanking by scanning the digits toward each end rather than by a chain.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef logic [3:0] bcd_t;
  typedef logic [6:0] seg_t;
  localparam bcd_t BCD_MAX = 4'd9;
  localparam seg_t SEG_OFF = 7'h00;
endpackage

// File: rtl/zs_seg_font.sv
module zs_seg_font
  import zs_pkg::*;
(
  input  bcd_t val_i,
  output seg_t seg_o
);
  always_comb begin
    unique case (val_i)
      4'd0:    seg_o = 7'h3F;
      4'd1:    seg_o = 7'h06;
      4'd2:    seg_o = 7'h5B;
      4'd3:    seg_o = 7'h4F;
      4'd4:    seg_o = 7'h66;
      4'd5:    seg_o = 7'h6D;
      4'd6:    seg_o = 7'h7D;
      4'd7:    seg_o = 7'h07;
      4'd8:    seg_o = 7'h7F;
      4'd9:    seg_o = 7'h6F;
      default: seg_o = SEG_OFF;
    endcase
  end
endmodule

// File: rtl/zs_zero_chain.sv
module zs_zero_chain #(
  parameter int NDIG = 8,
  parameter int IW   = 3
) (
  input  logic [4*NDIG-1:0] bcd_i,
  input  logic [IW-1:0]     idx_i,
  input  logic              en_i,
  output logic [NDIG-1:0]   blank_o
);
  always_comb begin
    logic run_hi;
    logic run_lo;
    blank_o = '0;
    // integer side: ripple from the top digit down toward the units digit
    run_hi = en_i;
    for (int i = NDIG - 1; i >= 0; i--) begin
      if (i > int'(idx_i)) begin
        blank_o[i] = run_hi && (bcd_i[4*i +: 4] == 4'd0);
        run_hi     = blank_o[i];
      end
    end
    // fractional side: ripple from digit 0 up toward the units digit
    run_lo = en_i;
    for (int i = 0; i < NDIG; i++) begin
      if (i < int'(idx_i)) begin
        blank_o[i] = run_lo && (bcd_i[4*i +: 4] == 4'd0);
        run_lo     = blank_o[i];
      end
    end
  end
endmodule

// File: rtl/zs_display_top.sv
module zs_display_top
  import zs_pkg::*;
#(
  parameter  int NDIG = 8,
  localparam int IW   = (NDIG > 1) ? $clog2(NDIG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4*NDIG-1:0] bcd_in,
  input  logic [IW-1:0]     dp_idx,
  input  logic              sup_en,
  output logic [7*NDIG-1:0] seg_o,
  output logic [NDIG-1:0]   dp_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NDIG-1:0]   blank;
  logic [7*NDIG-1:0] seg_d;
  logic [NDIG-1:0]   dp_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  zs_zero_chain #(.NDIG(NDIG), .IW(IW)) u_chain (
    .bcd_i   (bcd_in),
    .idx_i   (dp_idx),
    .en_i    (sup_en),
    .blank_o (blank)
  );

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    seg_t raw;
    zs_seg_font u_font (
      .val_i (bcd_in[4*g +: 4]),
      .seg_o (raw)
    );
    always_comb begin
      seg_d[7*g +: 7] = blank[g] ? SEG_OFF : raw;
      dp_d[g]         = (dp_idx == IW'(g));
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      seg_o <= '0;
      dp_o  <= '0;
    end else begin
      seg_o <= seg_d;
      dp_o  <= dp_d;
    end
  end
endmodule

// File: rtl/zs_display_chk.sv
module zs_display_chk #(
  parameter int NDIG = 8,
  parameter int IW   = 3
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [4*NDIG-1:0] bcd_in,
  input logic [IW-1:0]     dp_idx,
  input logic              sup_en,
  input logic [7*NDIG-1:0] seg_o,
  input logic [NDIG-1:0]   dp_o
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) seen_q <= 1'b0;
    else            seen_q <= 1'b1;
  end

  p_reset_dark_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !seen_q |-> (seg_o == '0 && dp_o == '0));

  p_dp_single_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    seen_q |-> $countones(dp_o) == 1);

  p_top_lead_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (seen_q && $past(sup_en) && $past(bcd_in[4*(NDIG-1) +: 4]) == 4'd0
     && $past(dp_idx) != IW'(NDIG-1)) |-> seg_o[7*(NDIG-1) +: 7] == 7'h00);

  for (genvar g = 0; g < NDIG; g++) begin : g_chk
    p_dp_place_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
      seen_q |-> dp_o[g] == ($past(dp_idx) == IW'(g)));

    p_unit_lit_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
      (seen_q && $past(dp_idx) == IW'(g) && $past(bcd_in[4*g +: 4]) <= 4'd9)
      |-> seg_o[7*g +: 7] != 7'h00);

    p_plain_lit_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
      (seen_q && !$past(sup_en) && $past(bcd_in[4*g +: 4]) <= 4'd9)
      |-> seg_o[7*g +: 7] != 7'h00);

    p_bad_dark_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
      (seen_q && $past(bcd_in[4*g +: 4]) > 4'd9) |-> seg_o[7*g +: 7] == 7'h00);
  end
endmodule

bind zs_display_top zs_display_chk #(.NDIG(NDIG), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .bcd_in    (bcd_in),
  .dp_idx    (dp_idx),
  .sup_en    (sup_en),
  .seg_o     (seg_o),
  .dp_o      (dp_o)
);

// File: tb/tb_zs_display_top.sv
module tb_zs_display_top;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int IW    = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [4*N-1:0]  bcd_in;
  logic [IW-1:0]   dp_idx;
  logic            sup_en;
  logic [7*N-1:0]  seg_o;
  logic [N-1:0]    dp_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [7*N-1:0] prev_seg;
  logic [N-1:0]   prev_dp;

  always #(CLK_P/2) clk = ~clk;

  zs_display_top #(.NDIG(N)) dut (
    .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .dp_idx(dp_idx),
    .sup_en(sup_en), .seg_o(seg_o), .dp_o(dp_o)
  );

  // R3 font table, g..a
  function automatic logic [6:0] font(input logic [3:0] v);
    case (v)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  // R5/R6/R7/R8/R9: blank by scanning toward the outer end of each side
  function automatic logic [7*N-1:0] exp_seg(input logic [4*N-1:0] b,
                                             input int idx, input bit en);
    logic [7*N-1:0] r;
    for (int i = 0; i < N; i++) begin
      bit all_zero = 1'b1;
      if (i > idx) begin
        for (int j = i; j < N; j++) if (b[4*j +: 4] != 0) all_zero = 1'b0;
      end else if (i < idx) begin
        for (int j = 0; j <= i; j++) if (b[4*j +: 4] != 0) all_zero = 1'b0;
      end else all_zero = 1'b0;
      r[7*i +: 7] = (en && all_zero) ? 7'h00 : font(b[4*i +: 4]);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [7*N-1:0] es,
                       input logic [N-1:0] ed);
    total++;
    if (seg_o !== es || dp_o !== ed) begin
      bad++;
      $display("FAIL %s seg=%h dp=%b expected seg=%h dp=%b", req, seg_o, dp_o, es, ed);
    end
  endtask

  task automatic apply(input logic [4*N-1:0] b, input int idx, input bit en,
                       input string req);
    logic [7*N-1:0] es = exp_seg(b, idx, en);
    logic [N-1:0]   ed = N'(1) << idx;
    bcd_in = b; dp_idx = IW'(idx); sup_en = en;
    #1;
    check("R2 hold before edge", prev_seg, prev_dp);
    @(negedge clk);
    check(req, es, ed);
    prev_seg = es; prev_dp = ed;
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bcd_in = '0; dp_idx = '0; sup_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", '0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    prev_seg = exp_seg('0, 0, 1'b0); prev_dp = N'(1);
    check("R8 settle", prev_seg, prev_dp);

    apply(32'h00000077, 0, 1'b1, "R5 leading zeros");
    apply(32'h77000000, 7, 1'b1, "R6 trailing zeros");
    apply(32'h00000000, 3, 1'b1, "R7 zero units digit");
    apply(32'h00000000, 3, 1'b0, "R8 suppression off");
    apply(32'h00500300, 4, 1'b1, "R5 R6 both sides");
    apply(32'hA0000010, 0, 1'b1, "R9 invalid stops integer chain");
    apply(32'h000000B0, 7, 1'b1, "R9 invalid stops fraction chain");
    apply(32'h0123456F, 2, 1'b0, "R3 font with invalid");
    apply(32'h98765432, 5, 1'b1, "R3 font all digits");
    apply(32'h00000000, 7, 1'b1, "R4 point at top");
    apply(32'h00000000, 0, 1'b1, "R4 point at bottom");

    void'($urandom(32'd4242));
    for (int k = 0; k < 400; k++) begin
      logic [4*N-1:0] b;
      for (int d = 0; d < N; d++) begin
        int r = $urandom % 8;
        b[4*d +: 4] = (r < 5) ? 4'd0 : (r == 7) ? 4'(10 + $urandom % 6)
                                                : 4'($urandom % 10);
      end
      apply(b, int'($urandom % N), bit'($urandom % 4 != 0), "R5 R6 R9 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule